// File: doc/BRIEF.md
# MDIO Management Master with Single Access Register

This block runs clause-22 management transactions toward external PHY devices. Software controls it through one 32-bit access word. That word carries the request flag, the direction, both addresses and the data. Software writes a word with the request flag set. The unit then shifts the whole frame out on MDC/MDIO and clears the flag when the frame is done. Software polls that flag to learn of completion. For a read, the 16 bits returned by the PHY replace the low half of the same word, so the result is picked up with the next read of the word.

A second command port serves other on-chip logic. It has a one-cycle request strobe with the command fields alongside it and a busy output. That port loads the same access word, so both masters see one shared state.

MDC comes from the system clock through a parameterized divider. The divider runs only while a frame is in flight and holds MDC low at all other times. MDIO changes only when MDC falls. Read data is sampled when MDC rises.

Top module: `mdio_acc_master`

The frame sequencer has nine states:
- `ST_IDLE`: waits for the request flag.
- `ST_PRE`: sends 32 ones.
- `ST_START`: sends 2 bits.
- `ST_OP`: sends 2 bits.
- `ST_PHY`: sends 5 bits.
- `ST_REG`: sends 5 bits.
- `ST_TURN`: covers 2 bits.
- `ST_DATA`: covers 16 bits.
- `ST_DONE`: lasts one cycle.

Transitions:
- `ST_IDLE` goes to `ST_PRE` when the flag is seen.
- Each transmitting state goes to the next state on the MDC falling edge that ends its last bit.
- `ST_DONE` always returns to `ST_IDLE`.

## Requirements
- R1: The access word layout is: bit 31 is the request flag, bit 30 is 1 for write and 0 for read, bits 25:21 hold the PHY address, bits 20:16 hold the register address, and bits 15:0 hold the data. Bits 29:26 are stored and returned unchanged.
- R2: A register write with bit 31 set, made while bit 31 is clear, starts a frame. Bit 31 (and `busy`) reads 1 for the whole frame and returns to 0 only after the frame completes.
- R3: Every frame starts with 32 ones. Then come start bits 0,1, opcode 0,1 for a write or 1,0 for a read, the 5-bit PHY address and the 5-bit register address, each sent MSB first.
- R4: In a write frame the unit drives turnaround 1,0 and then the 16 data bits MSB first, with `mdio_oe` high for all 64 bits. Writing 0xC0A09000 writes 0x9000 to register 0 of PHY 5. Writing 0xC0C09000 does the same to PHY 6.
- R5: In a read frame `mdio_oe` is low for the 2 turnaround bits and the 16 data bits. The data bits are taken from `mdio_i` on MDC rising edges, MSB first. After bit 31 clears, bits 15:0 hold the read value and bits 30:16 keep their written values.
- R6: While a frame runs, MDC has a period of 2·HALF_DIV system clocks. MDC is low whenever no frame runs. `mdio_o` changes while driven only in the cycle in which MDC falls.
- R7: A register write or a hardware request arriving while bit 31 is set changes neither the access word nor the frame in progress.
- R8: A `hw_req` pulse while idle loads {1, `hw_write`, 0000, `hw_phy`, `hw_reg`, `hw_wdata`} into the access word and starts a frame. If `reg_wr` arrives in the same cycle, the register write wins.
- R9: A register write with bit 31 clear stores the word and starts no frame, so MDC stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the access word |
| reg_wdata | input | 32 | Value written to the access word |
| reg_rdata | output | 32 | Current access word |
| hw_req | input | 1 | Hardware command strobe |
| hw_write | input | 1 | Hardware command direction, 1 = write |
| hw_phy | input | 5 | Hardware command PHY address |
| hw_reg | input | 5 | Hardware command register address |
| hw_wdata | input | 16 | Hardware command write data |
| busy | output | 1 | Frame in progress (request flag) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |

## Verification
The main patterns are two sweeps over all 32 PHY addresses, one of write frames and one of read frames:
- The register address is the complement of the PHY address and the data word changes with each index. A swapped field, a reversed bit order or an off-by-one shift gives a mismatch in the captured 64-bit frame.
- Read data returned by the modelled PHY changes with each index. This separates correct capture on rising edges from a one-bit slip and from an overwritten upper half.

Further cases:
- The two fixed command words confirm the field positions against known frames.
- Writes and hardware strobes injected in mid-frame must leave both the word and the wire unchanged.
- A word written with the request flag clear must produce no MDC edge at all.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int WORD_W = 32;

    // field positions inside the access word
    localparam int REQ_BIT = 31;
    localparam int WR_BIT  = 30;
    localparam int PHY_LO  = 21;
    localparam int REG_LO  = 16;

    // bit counts of each frame section
    localparam int PRE_LEN  = 32;
    localparam int START_LEN = 2;
    localparam int OP_LEN   = 2;
    localparam int TURN_LEN = 2;
    localparam int SHIFT_W  = START_LEN + OP_LEN + PHY_W + REG_W + TURN_LEN + DATA_W;
    localparam int FRAME_LEN = PRE_LEN + SHIFT_W;
    localparam int CNT_W    = $clog2(PRE_LEN + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TURN,
        ST_DATA,
        ST_DONE
    } mdio_state_e;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          mdc_q;
    logic          tick;

    assign tick = en && (cnt_q == LAST);
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: with the divider stopped, MDC is low one cycle later
    assert_mdc_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              is_write,
    input  logic [PHY_W-1:0]  phy,
    input  logic [REG_W-1:0]  regad,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              run,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mdio_o,
    output logic              mdio_oe
);

    mdio_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [SHIFT_W-1:0] tx_q;
    logic [DATA_W-1:0]  rx_q;
    logic [CNT_W-1:0]   span;
    logic               last_bit;

    // number of bit times spent in each state
    always_comb begin
        unique case (state_q)
            ST_PRE:   span = CNT_W'(PRE_LEN);
            ST_START: span = CNT_W'(START_LEN);
            ST_OP:    span = CNT_W'(OP_LEN);
            ST_PHY:   span = CNT_W'(PHY_W);
            ST_REG:   span = CNT_W'(REG_W);
            ST_TURN:  span = CNT_W'(TURN_LEN);
            ST_DATA:  span = CNT_W'(DATA_W);
            default:  span = CNT_W'(1);
        endcase
    end

    assign last_bit = (cnt_q == span - 1'b1);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req) state_d = ST_PRE;
            ST_PRE:   if (fall && last_bit) state_d = ST_START;
            ST_START: if (fall && last_bit) state_d = ST_OP;
            ST_OP:    if (fall && last_bit) state_d = ST_PHY;
            ST_PHY:   if (fall && last_bit) state_d = ST_REG;
            ST_REG:   if (fall && last_bit) state_d = ST_TURN;
            ST_TURN:  if (fall && last_bit) state_d = ST_DATA;
            ST_DATA:  if (fall && last_bit) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req) begin
                cnt_q <= '0;
                tx_q  <= {2'b01,
                          (is_write ? 2'b01 : 2'b10),
                          phy,
                          regad,
                          (is_write ? 2'b10 : 2'b00),
                          (is_write ? wdata : {DATA_W{1'b0}})};
            end else if (fall) begin
                cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
                if (state_q != ST_PRE) begin
                    tx_q <= {tx_q[SHIFT_W-2:0], 1'b0};
                end
            end
            if (rise && state_q == ST_DATA && !is_write) begin
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    // output decode
    always_comb begin
        run     = 1'b1;
        done    = 1'b0;
        mdio_o  = tx_q[SHIFT_W-1];
        mdio_oe = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                run     = 1'b0;
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
            ST_DONE: begin
                run     = 1'b0;
                done    = 1'b1;
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
            ST_PRE:  mdio_o = 1'b1;
            ST_TURN: mdio_oe = is_write;
            ST_DATA: mdio_oe = is_write;
            default: ;
        endcase
    end

    assign rdata = rx_q;

    // R3: the counter never exceeds the span of the current state
    assert_cnt_in_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_DONE) |-> (cnt_q < span));

endmodule

// File: rtl/mdio_acc_master.sv
module mdio_acc_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        hw_req,
    input  logic        hw_write,
    input  logic [4:0]  hw_phy,
    input  logic [4:0]  hw_reg,
    input  logic [15:0] hw_wdata,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [WORD_W-1:0] acc_q;
    logic              run, done, rise, fall;
    logic [DATA_W-1:0] rd_val;

    // access word: command, result and completion flag in one place
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (done) begin
            acc_q[REQ_BIT] <= 1'b0;
            if (!acc_q[WR_BIT]) begin
                acc_q[DATA_W-1:0] <= rd_val;
            end
        end else if (!acc_q[REQ_BIT]) begin
            if (reg_wr) begin
                acc_q <= reg_wdata;
            end else if (hw_req) begin
                acc_q <= {1'b1, hw_write, 4'b0000, hw_phy, hw_reg, hw_wdata};
            end
        end
    end

    assign reg_rdata = acc_q;
    assign busy      = acc_q[REQ_BIT];

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .mdc   (mdc),
        .rise  (rise),
        .fall  (fall)
    );

    mdio_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (acc_q[REQ_BIT]),
        .is_write (acc_q[WR_BIT]),
        .phy      (acc_q[PHY_LO +: PHY_W]),
        .regad    (acc_q[REG_LO +: REG_W]),
        .wdata    (acc_q[DATA_W-1:0]),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .run      (run),
        .done     (done),
        .rdata    (rd_val),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    // R2: completion clears the flag on the next edge
    assert_done_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !acc_q[REQ_BIT]);

    // R2: the flag only drops as a result of completion
    assert_clear_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_q[REQ_BIT]) |-> $past(done));

    // R7: writes while busy leave the word untouched
    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_q[REQ_BIT]) && !$past(done)) |-> (acc_q == $past(acc_q)));

    // R6: driven data only moves together with a falling MDC
    assert_mdio_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

endmodule

// File: tb/sim_mdio_acc_master.sv
module sim_mdio_acc_master;

    localparam int HALF = 2;
    localparam time MDC_PERIOD = 2 * HALF * 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        hw_req = 1'b0;
    logic        hw_write = 1'b0;
    logic [4:0]  hw_phy = '0;
    logic [4:0]  hw_reg = '0;
    logic [15:0] hw_wdata = '0;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int rises  = 0;
    bit ended  = 0;

    logic [63:0] cap_d, cap_oe;
    time t_r0, t_r1;

    always #5 clk = ~clk;
    always @(posedge mdc) rises++;

    mdio_acc_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hw_req(hw_req), .hw_write(hw_write),
        .hw_phy(hw_phy), .hw_reg(hw_reg), .hw_wdata(hw_wdata), .busy(busy),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r,
                (w ? 2'b10 : 2'b00), (w ? d : 16'h0000)};
    endfunction

    function automatic logic [63:0] exp_oe(input logic w);
        return w ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
    endfunction

    task automatic sw_write(input logic [31:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic hw_issue(input logic w, input logic [4:0] p, input logic [4:0] r,
                            input logic [15:0] d);
        @(negedge clk); hw_req = 1'b1; hw_write = w; hw_phy = p; hw_reg = r; hw_wdata = d;
        @(negedge clk); hw_req = 1'b0;
    endtask

    // PHY model: captures 64 rising-edge bits, drives read data after falls
    task automatic phy_talk(input logic [63:0] rd_bits, input bit poke,
                            input logic [31:0] word_now);
        mdio_i = 1'b1;
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc); #1;
            cap_d[63-k]  = mdio_o;
            cap_oe[63-k] = mdio_oe;
            if (k == 0) t_r0 = $time;
            if (k == 1) t_r1 = $time;
            if (poke && k == 20) begin
                @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h8FFF_1234;
                hw_req = 1'b1; hw_write = 1'b1; hw_phy = 5'h1F; hw_reg = 5'h1F;
                @(negedge clk); reg_wr = 1'b0; hw_req = 1'b0;
                chk("R7 word held during busy", {32'h0, reg_rdata}, {32'h0, word_now});
            end
            @(negedge mdc); #1;
            if (k >= 47 && k <= 62) mdio_i = rd_bits[62-k];
            else mdio_i = 1'b1;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    // full transaction and all frame checks
    task automatic run_txn(input bit use_hw, input logic w, input logic [4:0] p,
                           input logic [4:0] r, input logic [15:0] d,
                           input logic [15:0] phy_ret, input bit poke, input string tag);
        logic [31:0] word;
        logic [31:0] fin;
        word = {1'b1, w, 4'b0000, p, r, d};
        if (use_hw) hw_issue(w, p, r, d);
        else sw_write(word);
        chk({tag, " R2 busy set"}, {63'h0, busy}, 64'h1);
        phy_talk({48'h0, phy_ret}, poke, word);
        chk({tag, " R3 frame"}, cap_d & exp_oe(w), exp_frame(w, p, r, d));
        chk({tag, w ? " R4 drive" : " R5 release"}, cap_oe, exp_oe(w));
        chk({tag, " R6 period"}, 64'(t_r1 - t_r0), 64'(MDC_PERIOD));
        wait_idle();
        fin = {1'b0, w, 4'b0000, p, r, (w ? d : phy_ret)};
        chk({tag, w ? " R2 completion" : " R5 readback"}, {32'h0, reg_rdata}, {32'h0, fin});
    endtask

    initial begin
        #1_500_000;
        if (!ended) begin
            ended = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", {32'h0, reg_rdata}, 64'h0);
        chk("R6 reset mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);

        // R4: fixed command words
        run_txn(0, 1'b1, 5'd5, 5'd0, 16'h9000, 16'h0, 0, "R4 0xC0A09000");
        chk("R1 encoding check", {32'h0, 32'hC0A09000}, {32'h0, 1'b1, 1'b1, 4'b0, 5'd5, 5'd0, 16'h9000});
        run_txn(0, 1'b1, 5'd6, 5'd0, 16'h9000, 16'h0, 0, "R4 0xC0C09000");

        // R3/R4 write sweep over all PHY addresses
        for (int p = 0; p < 32; p++) begin
            run_txn(0, 1'b1, 5'(p), 5'(31 - p), 16'((p * 16'h0811) ^ 16'hA5C3),
                    16'h0, 0, "R4 sweep");
        end
        // R5 read sweep
        for (int p = 0; p < 32; p++) begin
            run_txn(0, 1'b0, 5'(p), 5'(~p), 16'h0, 16'(~(p * 16'h1357)), 0, "R5 sweep");
        end

        // R7 mid-frame writes and hw strobes ignored
        run_txn(0, 1'b1, 5'd9, 5'd3, 16'h3C5A, 16'h0, 1, "R7 write");
        run_txn(0, 1'b0, 5'd17, 5'd2, 16'h0, 16'hBEEF, 1, "R7 read");

        // R8 hardware port
        run_txn(1, 1'b1, 5'd3, 5'd7, 16'h1234, 16'h0, 0, "R8 hw write");
        run_txn(1, 1'b0, 5'd12, 5'd30, 16'h0, 16'h8001, 0, "R8 hw read");

        // R8 register write wins over a simultaneous hw strobe (request flag clear)
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 32'h0123_4567;
        hw_req = 1'b1; hw_write = 1'b1; hw_phy = 5'd1; hw_reg = 5'd1; hw_wdata = 16'hFFFF;
        @(negedge clk);
        reg_wr = 1'b0; hw_req = 1'b0;
        chk("R8 register write priority", {32'h0, reg_rdata}, 64'h0123_4567);

        // R9 flag clear: stored, no frame
        begin
            int r0;
            r0 = rises;
            sw_write(32'h3E5A_C0DE);
            repeat (60) @(negedge clk);
            chk("R9 no mdc edges", 64'(rises - r0), 64'h0);
            chk("R9 word stored", {32'h0, reg_rdata}, 64'h3E5A_C0DE);
            chk("R9 not busy", {63'h0, busy}, 64'h0);
        end

        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule